// File: doc/BRIEF.md
# Narrow Pulse Capture Synchronizer

This block brings an unclocked event into a clock domain when that event may be far shorter than one clock period. A rising edge on the raw event input sets a sticky flag straight away, without waiting for a clock edge. The flag stays set after the pulse has gone. A chain of flip-flops then carries the flag into the clock domain, so that metastability is contained before any clocked logic reads it. The domain sees a level that says an event is pending and a one-cycle strobe when that level first rises.

The consumer in the clock domain handles the event and then raises an acknowledge for one or more cycles. The acknowledge releases the flag, and that re-arms the block. A raw pulse that is active at the clock edge where the acknowledge is sampled wins, so the flag stays set. A second rising edge that arrives while the flag is already set is merged into the pending event. A separate one-cycle overflow strobe reports the merge. The block carries no data. All of its pins are plain control and status signals, so there is no valid/ready handshake and no back-pressure.

Top module: `pulse_catch_sync`

## Requirements
- R1: While the synchronous reset is high, and after it has been held for two clock edges, `pend_o`, `stb_o` and `ovf_o` are all 0. A flag caught before the reset is discarded: no strobe and no pending level follows once the reset is released, unless a new pulse arrives.
- R2: A rising edge on `evt_i` of any width, including one that starts and ends between two clock edges, is caught. `pend_o` goes high after the second rising clock edge that follows the pulse edge (the default depth is two synchronizer stages).
- R3: `stb_o` is high for exactly one cycle, in the first cycle in which `pend_o` is high after being low.
- R4: Once `pend_o` is high it stays high until `ack_i` is sampled high. If `ack_i` is sampled high at clock edge m while `evt_i` is low, `pend_o` falls after edge m+2.
- R5: `ack_i` while no event is pending has no effect. `pend_o`, `stb_o` and `ovf_o` stay 0.
- R6: A rising edge on `evt_i` while the flag is already set causes no second strobe. It gives a one-cycle `ovf_o` pulse two clock edges later, and the event stays pending.
- R7: If `evt_i` is high at the clock edge where `ack_i` is sampled, the clear does not take effect. `pend_o` stays high without a gap, and no new `stb_o` is produced.
- R8: After a clear has taken effect and `pend_o` has fallen, a new pulse produces a new pending level and a new strobe.
- R9: A pulse that stays high for several clock cycles produces exactly one strobe and no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Destination clock |
| rst_i | input | 1 | Synchronous reset, active high |
| evt_i | input | 1 | Raw event, unclocked; its rising edge sets the flag |
| ack_i | input | 1 | Acknowledge from the consumer; releases the flag |
| pend_o | output | 1 | Event pending, synchronized level |
| stb_o | output | 1 | One-cycle strobe when a new event becomes pending |
| ovf_o | output | 1 | One-cycle strobe when a pulse was merged into a pending event |

## Verification
A flag that fails to latch shows up as a missing `pend_o` two edges after the pulse. A flag that fails to hold, or that clears on an acknowledge it should ignore, shows up as `pend_o` dropping within three cycles of that acknowledge. A synchronizer stage that is missing or reset wrongly moves the rise of `pend_o` and `stb_o` by one cycle, and a broken edge detector gives a strobe that is too long or repeated. The reference model is compared with all three outputs on every cycle, so any of these faults is reported in the cycle in which it first becomes visible.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  // number of flip-flops between the sticky flag and clocked logic
  localparam int unsigned PCS_SYNC_DEPTH = 2;

  typedef enum logic {
    EDGE_RISE   = 1'b0,
    EDGE_CHANGE = 1'b1
  } pcs_edge_kind_e;
endpackage

// File: rtl/pcs_catch.sv
// Sticky event flag with asynchronous set and synchronous release, plus a
// toggle that flips whenever a new edge lands on an already set flag.
module pcs_catch (
  input  logic clk_i,
  input  logic rst_i,
  input  logic evt_i,
  input  logic clr_i,
  output logic flag_o,
  output logic merge_tog_o
);
  logic flag_q;
  logic tog_q = 1'b0;

  // set wins over release: a live pulse keeps the flag up
  always_ff @(posedge clk_i or posedge evt_i) begin
    if (evt_i)
      flag_q <= 1'b1;
    else if (rst_i || clr_i)
      flag_q <= 1'b0;
  end

  // samples the flag as it was before this edge
  always_ff @(posedge evt_i) begin
    if (flag_q)
      tog_q <= ~tog_q;
  end

  assign flag_o      = flag_q;
  assign merge_tog_o = tog_q;

  // R4: a set flag survives every clock edge without reset or release
  p_flag_sticky_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (flag_q && !clr_i) |=> flag_q);
endmodule

// File: rtl/pcs_sync.sv
// Multi-stage synchronizer chain; optional synchronous reset.
module pcs_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          USE_RST = 1'b1
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] st_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic nxt;
    if (i == 0) begin : g_head
      assign nxt = d_i;
    end else begin : g_body
      assign nxt = st_q[i-1];
    end
    always_ff @(posedge clk_i) begin
      if (USE_RST && rst_i)
        st_q[i] <= 1'b0;
      else
        st_q[i] <= nxt;
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/pcs_edge.sv
// Single-cycle detector on a synchronized level; kind picks rise or change.
module pcs_edge
  import pcs_pkg::*;
#(
  parameter pcs_edge_kind_e KIND    = EDGE_RISE,
  parameter bit             USE_RST = 1'b1
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic lvl_i,
  output logic hit_o
);
  logic prev_q;
  logic raw;

  always_ff @(posedge clk_i) begin
    if (USE_RST && rst_i)
      prev_q <= 1'b0;
    else
      prev_q <= lvl_i;
  end

  if (KIND == EDGE_RISE) begin : g_rise
    assign raw = lvl_i & ~prev_q;
  end else begin : g_change
    assign raw = lvl_i ^ prev_q;
  end

  assign hit_o = raw & ~rst_i;
endmodule

// File: rtl/pulse_catch_sync.sv
module pulse_catch_sync
  import pcs_pkg::*;
#(
  parameter int unsigned SYNC_DEPTH = PCS_SYNC_DEPTH
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic evt_i,
  input  logic ack_i,
  output logic pend_o,
  output logic stb_o,
  output logic ovf_o
);
  logic flag;
  logic merge_tog;
  logic tog_sync;

  pcs_catch u_catch (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .evt_i       (evt_i),
    .clr_i       (ack_i),
    .flag_o      (flag),
    .merge_tog_o (merge_tog)
  );

  pcs_sync #(.STAGES(SYNC_DEPTH), .USE_RST(1'b1)) u_flag_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (flag),
    .q_o   (pend_o)
  );

  pcs_edge #(.KIND(EDGE_RISE), .USE_RST(1'b1)) u_new_evt (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .lvl_i (pend_o),
    .hit_o (stb_o)
  );

  // toggle path is left unreset; its stages settle while reset is held
  pcs_sync #(.STAGES(SYNC_DEPTH), .USE_RST(1'b0)) u_tog_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (merge_tog),
    .q_o   (tog_sync)
  );

  pcs_edge #(.KIND(EDGE_CHANGE), .USE_RST(1'b0)) u_merge (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .lvl_i (tog_sync),
    .hit_o (ovf_o)
  );

  // R2: pending only rises for a flag held two edges earlier
  p_rise_from_flag_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(pend_o) |-> $past(flag, 2));

  // R3: strobe never lasts beyond one cycle
  p_strobe_alone_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    stb_o |=> !stb_o);

  // R3: strobe only when pending has just come up
  p_strobe_on_rise_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    stb_o |-> (pend_o && !$past(pend_o)));
endmodule

// File: tb/pulse_catch_sync_tb_top.sv
module pulse_catch_sync_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic evt = 1'b0;
  logic ack = 1'b0;
  logic pend, stb, ovf;

  int total = 0;
  int bad = 0;
  int stb_cnt = 0;
  int ovf_cnt = 0;
  bit armed = 1'b0;
  string cur_req = "R1";

  // reference model state
  bit m_flag = 1'b0;
  bit m_tog = 1'b0;
  bit f1 = 1'b0, f2 = 1'b0;
  bit t1 = 1'b0, t2 = 1'b0, t3 = 1'b0;
  bit e_pend = 1'b0, e_pend_prev = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  pulse_catch_sync dut_i (
    .clk_i (clk), .rst_i (rst), .evt_i (evt), .ack_i (ack),
    .pend_o (pend), .stb_o (stb), .ovf_o (ovf)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // model update at each clock edge
  always @(posedge clk) begin
    e_pend_prev = e_pend;
    f2 = f1; f1 = m_flag;
    t3 = t2; t2 = t1; t1 = m_tog;
    if (rst) begin
      f1 = 1'b0; f2 = 1'b0; e_pend = 1'b0; e_pend_prev = 1'b0;
    end else begin
      e_pend = f2;
    end
    if (evt) m_flag = 1'b1;
    else if (rst || ack) m_flag = 1'b0;
  end

  // compare every cycle, away from the edge
  always @(negedge clk) begin
    if (armed) begin
      check(cur_req, "pend_o", pend, e_pend);
      check(cur_req, "stb_o", stb, (e_pend && !e_pend_prev && !rst));
      check(cur_req, "ovf_o", ovf, ((t2 ^ t3) && !rst));
      if (stb) stb_cnt++;
      if (ovf) ovf_cnt++;
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // pulse rising at negedge + dly, high for wid ns
  task automatic pulse(input realtime dly, input realtime wid);
    @(negedge clk);
    #(dly);
    if (m_flag) m_tog = ~m_tog;
    m_flag = 1'b1;
    evt = 1'b1;
    #(wid);
    evt = 1'b0;
  endtask

  task automatic do_ack;
    @(negedge clk); #1 ack = 1'b1;
    @(negedge clk); #1 ack = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    total++; bad++;
    $display("FAIL watchdog expired t=%0t", $time);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s0, o0;
    // R1: reset state
    cycles(3);
    armed = 1'b1;
    check("R1", "pend_o in reset", pend, 0);
    check("R1", "stb_o in reset", stb, 0);
    check("R1", "ovf_o in reset", ovf, 0);
    @(negedge clk); #1 rst = 1'b0;
    cycles(3);

    // R2/R3: narrow pulse between edges
    cur_req = "R2";
    s0 = stb_cnt;
    pulse(0.5, 0.5);
    @(negedge clk);            // one edge passed
    check("R2", "pend_o after one edge", pend, 0);
    @(negedge clk);            // second edge passed
    check("R2", "pend_o after two edges", pend, 1);
    check("R3", "stb_o on rise", stb, 1);
    cycles(1);
    check("R3", "stb_o second cycle", stb, 0);

    // R4: hold until acknowledged
    cur_req = "R4";
    cycles(10);
    check("R4", "pend_o held", pend, 1);
    check("R3", "single strobe", stb_cnt - s0, 1);
    do_ack();
    cycles(3);
    check("R4", "pend_o released", pend, 0);

    // R5: stray acknowledge
    cur_req = "R5";
    s0 = stb_cnt;
    do_ack(); do_ack();
    cycles(4);
    check("R5", "pend_o idle after ack", pend, 0);
    check("R5", "no strobe from ack", stb_cnt - s0, 0);

    // R6: merge while pending
    cur_req = "R6";
    s0 = stb_cnt; o0 = ovf_cnt;
    pulse(0.5, 0.5);
    cycles(4);
    pulse(0.7, 0.3);
    cycles(4);
    check("R6", "overflow count", ovf_cnt - o0, 1);
    check("R6", "strobe count", stb_cnt - s0, 1);
    check("R6", "still pending", pend, 1);

    // R7: pulse live at the ack edge
    cur_req = "R7";
    s0 = stb_cnt;
    @(negedge clk); #1 ack = 1'b1;
    #0.2;
    if (m_flag) m_tog = ~m_tog;
    m_flag = 1'b1;
    evt = 1'b1;
    @(negedge clk); #0.5 evt = 1'b0;
    #0.5 ack = 1'b0;
    cycles(5);
    check("R7", "pend_o kept", pend, 1);
    check("R7", "no new strobe", stb_cnt - s0, 0);
    do_ack();
    cycles(3);
    check("R7", "pend_o cleared later", pend, 0);

    // R8: re-arm after clear
    cur_req = "R8";
    s0 = stb_cnt;
    pulse(1.0, 0.4);
    cycles(3);
    check("R8", "pend_o re-armed", pend, 1);
    check("R8", "new strobe", stb_cnt - s0, 1);

    // R1: reset discards a caught event
    cur_req = "R1";
    s0 = stb_cnt;
    @(negedge clk); #1 rst = 1'b1;
    cycles(3);
    @(negedge clk); #1 rst = 1'b0;
    cycles(5);
    check("R1", "pend_o after reset", pend, 0);
    check("R1", "no strobe after reset", stb_cnt - s0, 0);

    // R9: wide pulse
    cur_req = "R9";
    s0 = stb_cnt; o0 = ovf_cnt;
    pulse(0.5, 24.0);
    cycles(6);
    check("R9", "one strobe", stb_cnt - s0, 1);
    check("R9", "no overflow", ovf_cnt - o0, 0);
    do_ack();
    cycles(4);
    check("R9", "released", pend, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule